// File: doc/BRIEF.md
# Multi-Key Simultaneous-Low Reset Detector

This block watches four active-low key inputs and raises a reset request when a software-chosen group of them is held low together. A two-bit selection code in a small configuration register sets the group. The group always starts at key 0 and grows upward: code 1 needs keys 0 and 1, code 2 needs keys 0 to 2, and code 3 needs all four keys. Code 0 turns the function off. Code 0 is also the value after power-up, so the detector cannot act as a power-on reset source.

Each key passes through a two-flop synchronizer. The chosen keys must stay low for `HOLD_CYCLES` consecutive clocks before the block acts. When that count completes, `rst_req` goes high for exactly `PULSE_LEN` clocks. A key combination that stays held produces only one pulse. The keys must leave the combination before another pulse can be produced.

The block's own `rst` input must come from power-on reset only. This keeps the selection code intact across the reset that the block itself requests.

Top module: `key_combo_reset`

## Requirements
- R1: After `rst`, the selection code is 0, `rst_req` is low, and a read of offset 0x9 returns 0x00.
- R2: A write with `cfg_addr` = 0x9 loads `cfg_wdata[1:0]` into the selection code. Bits [7:2] of the write data are ignored. Writes to any other offset leave the code unchanged. `cfg_rdata` shows the code in bits [1:0] (upper bits 0) when `cfg_addr` = 0x9, and 0x00 at any other offset.
- R3: With code 0, no key pattern ever raises `rst_req`.
- R4: Code n (1 to 3) requires keys 0 through n to be low. Keys above n are ignored. If any required key is high, no request is made.
- R5: A qualifying combination that is low at the pins for L consecutive sampled clocks raises `rst_req` exactly `HOLD_CYCLES`+2 clocks after it is first applied, provided L ≥ `HOLD_CYCLES`. A shorter combination raises nothing.
- R6: Once raised, `rst_req` stays high for exactly `PULSE_LEN` clocks and then falls.
- R7: A combination held past the pulse does not produce a second pulse. After the combination is released, pressing it again produces a new pulse.
- R8: The selection code is not changed by the block's own request. After a pulse, the code still reads back the value that was written.
- R9: A code write takes effect from the clock after the edge that samples it. A write of 0 sampled on the same edge as the completing hold count does not cancel that pulse. A write of 0 sampled one edge earlier does cancel it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high power-on reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_addr | input | 4 | Configuration byte offset |
| cfg_wdata | input | 8 | Configuration write data |
| cfg_rdata | output | 8 | Configuration read data for `cfg_addr` |
| key_n | input | 4 | Active-low key inputs, key 0 in bit 0 |
| rst_req | output | 1 | Reset request pulse |

## Verification
Two functions can meet on one clock edge: a software write that clears the selection code, and the edge on which the hold counter completes and launches the pulse. The bench holds all four keys low and times a write of 0 so that the edge sampling the write is the completion edge. A pulse is then required. It repeats the run with the write one edge earlier, where no pulse is allowed. Both cases are judged by comparing `rst_req` on every cycle against a window computed from `HOLD_CYCLES` and `PULSE_LEN`.

// File: rtl/kpr_pkg.sv
package kpr_pkg;

    localparam int KEY_COUNT = 4;

    typedef enum logic [1:0] {
        KSEL_OFF  = 2'd0,
        KSEL_TWO  = 2'd1,
        KSEL_THREE = 2'd2,
        KSEL_FOUR = 2'd3
    } ksel_e;

    typedef struct packed {
        logic match;
        logic fire;
    } det_s;

    // Keys that must be low for a given selection code: a prefix from key 0.
    function automatic logic [KEY_COUNT-1:0] sel_mask(input ksel_e code);
        logic [KEY_COUNT-1:0] m;
        m = '0;
        for (int i = 0; i < KEY_COUNT; i++) begin
            if (code != KSEL_OFF && i <= int'(code)) m[i] = 1'b1;
        end
        return m;
    endfunction

endpackage

// File: rtl/kpr_cfg_reg.sv
module kpr_cfg_reg
    import kpr_pkg::*;
#(
    parameter int          ADDR_W     = 4,
    parameter int          DATA_W     = 8,
    parameter logic [ADDR_W-1:0] CFG_OFFSET = ADDR_W'(9)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              we,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] rdata,
    output ksel_e             code
);

    logic hit;
    logic wdata_unused;

    assign hit          = (addr == CFG_OFFSET);
    assign wdata_unused = ^wdata[DATA_W-1:2];

    always_ff @(posedge clk) begin
        if (rst) begin
            code <= KSEL_OFF;
        end else if (we && hit) begin
            code <= ksel_e'(wdata[1:0]);
        end
    end

    always_comb begin
        rdata = '0;
        if (hit) rdata[1:0] = code;
    end

endmodule

// File: rtl/kpr_sync.sv
module kpr_sync #(
    parameter int WIDTH  = 4,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [WIDTH-1:0] din,
    output logic [WIDTH-1:0] dout
);

    generate
        for (genvar b = 0; b < WIDTH; b++) begin : g_bit
            logic [STAGES-1:0] chain;
            always_ff @(posedge clk) begin
                if (rst) chain <= '1;
                else     chain <= {chain[STAGES-2:0], din[b]};
            end
            assign dout[b] = chain[STAGES-1];
        end
    endgenerate

endmodule

// File: rtl/kpr_detect.sv
module kpr_detect
    import kpr_pkg::*;
#(
    parameter int HOLD_CYCLES = 8,
    localparam int CNT_W = $clog2(HOLD_CYCLES + 1)
) (
    input  logic                 clk,
    input  logic                 rst,
    input  ksel_e                code,
    input  logic [KEY_COUNT-1:0] keys_s,
    output det_s                 det,
    output logic [CNT_W-1:0]     hold_cnt
);

    localparam logic [CNT_W-1:0] LAST = CNT_W'(HOLD_CYCLES - 1);

    logic [KEY_COUNT-1:0] mask;
    logic                 armed;

    assign mask      = sel_mask(code);
    assign det.match = (mask != '0) && ((keys_s & mask) == '0);
    assign det.fire  = det.match && armed && (hold_cnt == LAST);

    always_ff @(posedge clk) begin
        if (rst) begin
            hold_cnt <= '0;
            armed    <= 1'b1;
        end else if (!det.match) begin
            hold_cnt <= '0;
            armed    <= 1'b1;
        end else if (armed) begin
            if (hold_cnt == LAST) begin
                hold_cnt <= '0;
                armed    <= 1'b0;
            end else begin
                hold_cnt <= hold_cnt + 1'b1;
            end
        end
    end

endmodule

// File: rtl/kpr_pulse.sv
module kpr_pulse #(
    parameter int PULSE_LEN = 16,
    localparam int PC_W = $clog2(PULSE_LEN + 1)
) (
    input  logic clk,
    input  logic rst,
    input  logic fire,
    output logic req
);

    logic [PC_W-1:0] left;

    always_ff @(posedge clk) begin
        if (rst) begin
            left <= '0;
            req  <= 1'b0;
        end else if (fire) begin
            left <= PC_W'(PULSE_LEN - 1);
            req  <= 1'b1;
        end else if (left != '0) begin
            left <= left - 1'b1;
            req  <= 1'b1;
        end else begin
            req  <= 1'b0;
        end
    end

endmodule

// File: rtl/key_combo_reset.sv
module key_combo_reset
    import kpr_pkg::*;
#(
    parameter int ADDR_W      = 4,
    parameter int DATA_W      = 8,
    parameter int HOLD_CYCLES = 8,
    parameter int PULSE_LEN   = 16,
    parameter int SYNC_STAGES = 2,
    localparam int CNT_W = $clog2(HOLD_CYCLES + 1)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              cfg_we,
    input  logic [ADDR_W-1:0] cfg_addr,
    input  logic [DATA_W-1:0] cfg_wdata,
    output logic [DATA_W-1:0] cfg_rdata,
    input  logic [3:0]        key_n,
    output logic              rst_req
);

    ksel_e                code;
    logic [1:0]           cfg_code_w;
    logic [KEY_COUNT-1:0] keys_s;
    det_s                 det;
    logic [CNT_W-1:0]     hold_cnt_w;

    assign cfg_code_w = code;

    kpr_cfg_reg #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .CFG_OFFSET(ADDR_W'(9))) u_cfg (
        .clk(clk), .rst(rst), .we(cfg_we), .addr(cfg_addr),
        .wdata(cfg_wdata), .rdata(cfg_rdata), .code(code)
    );

    kpr_sync #(.WIDTH(KEY_COUNT), .STAGES(SYNC_STAGES)) u_sync (
        .clk(clk), .rst(rst), .din(key_n), .dout(keys_s)
    );

    kpr_detect #(.HOLD_CYCLES(HOLD_CYCLES)) u_det (
        .clk(clk), .rst(rst), .code(code), .keys_s(keys_s),
        .det(det), .hold_cnt(hold_cnt_w)
    );

    kpr_pulse #(.PULSE_LEN(PULSE_LEN)) u_pulse (
        .clk(clk), .rst(rst), .fire(det.fire), .req(rst_req)
    );

endmodule

// File: rtl/kpr_checker.sv
module kpr_checker #(
    parameter int ADDR_W      = 4,
    parameter int HOLD_CYCLES = 8,
    parameter int PULSE_LEN   = 16,
    localparam int CNT_W = $clog2(HOLD_CYCLES + 1),
    localparam int HC_W  = $clog2(PULSE_LEN + 2) + 1
) (
    input logic              clk,
    input logic              rst,
    input logic              cfg_we,
    input logic [ADDR_W-1:0] cfg_addr,
    input logic [1:0]        cfg_code,
    input logic [CNT_W-1:0]  hold_cnt,
    input logic              rst_req
);

    logic [HC_W-1:0] hi_cnt;

    always_ff @(posedge clk) begin
        if (rst)          hi_cnt <= '0;
        else if (rst_req) hi_cnt <= hi_cnt + 1'b1;
        else              hi_cnt <= '0;
    end

    AST_CODE_HOLD: assert property (@(posedge clk) disable iff (rst)
        !(cfg_we && cfg_addr == ADDR_W'(9)) |=> $stable(cfg_code)); // R2

    AST_OFF_QUIET: assert property (@(posedge clk) disable iff (rst)
        $rose(rst_req) |-> $past(cfg_code) != 2'd0); // R3

    AST_HOLD_DONE: assert property (@(posedge clk) disable iff (rst)
        $rose(rst_req) |-> $past(hold_cnt) == CNT_W'(HOLD_CYCLES - 1)); // R5

    AST_PULSE_WIDTH: assert property (@(posedge clk) disable iff (rst)
        $fell(rst_req) |-> hi_cnt >= HC_W'(PULSE_LEN)); // R6

endmodule

bind key_combo_reset kpr_checker #(
    .ADDR_W(ADDR_W), .HOLD_CYCLES(HOLD_CYCLES), .PULSE_LEN(PULSE_LEN)
) u_chk (
    .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
    .cfg_code(cfg_code_w), .hold_cnt(hold_cnt_w), .rst_req(rst_req)
);

// File: tb/tb_key_combo_reset.sv
module tb_key_combo_reset;

    localparam int CLK_PERIOD = 10;
    localparam int HOLD       = 6;
    localparam int PULSE      = 16;
    localparam int WIN        = HOLD + 30;

    logic       clk = 1'b0;
    logic       rst;
    logic       cfg_we;
    logic [3:0] cfg_addr;
    logic [7:0] cfg_wdata;
    logic [7:0] cfg_rdata;
    logic [3:0] key_n;
    logic       rst_req;

    int n_chk = 0;
    int n_bad = 0;
    int cyc   = 0;

    always #(CLK_PERIOD/2) clk = ~clk;
    always @(posedge clk) cyc++;

    key_combo_reset #(.HOLD_CYCLES(HOLD), .PULSE_LEN(PULSE)) dut (
        .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
        .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata), .key_n(key_n), .rst_req(rst_req)
    );

    task automatic report();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    endtask

    task automatic check(input string tag, input logic [7:0] act, input logic [7:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic step();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic cfg_write(input logic [3:0] a, input logic [7:0] d);
        cfg_we = 1'b1; cfg_addr = a; cfg_wdata = d;
        step();
        cfg_we = 1'b0; cfg_addr = 4'h9;
    endtask

    task automatic read_check(input string tag, input logic [3:0] a, input logic [7:0] exp);
        cfg_addr = a;
        #1;
        check(tag, cfg_rdata, exp);
        cfg_addr = 4'h9;
    endtask

    task automatic idle(input int n);
        key_n = 4'hF;
        for (int i = 0; i < n; i++) step();
    endtask

    // Apply pattern for len edges; optional write of code 0 sampled at edge wr_at+1.
    task automatic press(input string tag, input logic [3:0] pat, input int len,
                         input bit fire_exp, input int wr_at);
        int  bad_k;
        logic seen;
        bad_k = 0; seen = 1'b0;
        key_n = pat;
        for (int k = 1; k <= WIN; k++) begin
            step();
            begin
                logic e;
                e = fire_exp && (k >= HOLD + 2) && (k <= HOLD + 1 + PULSE);
                if (rst_req !== e && bad_k == 0) begin
                    bad_k = k; seen = rst_req;
                end
            end
            if (k == len) key_n = 4'hF;
            if (cfg_we) begin cfg_we = 1'b0; end
            if (wr_at != 0 && k == wr_at) begin
                cfg_we = 1'b1; cfg_addr = 4'h9; cfg_wdata = 8'h00;
            end
        end
        cfg_we = 1'b0;
        n_chk++;
        if (bad_k != 0) begin
            n_bad++;
            $display("FAIL %s cycle %0d rst_req actual=%b expected=%b",
                     tag, bad_k, seen, ~seen);
        end
        idle(4);
    endtask

    initial begin
        while (cyc < 100000) @(posedge clk);
        n_chk++; n_bad++;
        $display("FAIL watchdog actual=timeout expected=finish");
        report();
    end

    initial begin
        rst = 1'b1; cfg_we = 1'b0; cfg_addr = 4'h9; cfg_wdata = '0; key_n = 4'hF;
        repeat (3) step();
        rst = 1'b0;
        step();

        // R1: reset state
        check("R1 rst_req", {7'b0, rst_req}, 8'h00);
        read_check("R1 code", 4'h9, 8'h00);

        // R2: upper bits ignored, other offsets ignored
        cfg_write(4'h9, 8'hFE);
        read_check("R2 upper bits", 4'h9, 8'h02);
        cfg_write(4'h8, 8'h01);
        read_check("R2 other offset write", 4'h9, 8'h02);
        read_check("R2 other offset read", 4'h8, 8'h00);

        // R3: disabled
        cfg_write(4'h9, 8'h00);
        press("R3 code0 all low", 4'h0, WIN, 1'b0, 0);

        // R4: prefix selection
        cfg_write(4'h9, 8'h01);
        press("R4 code1 keys2-3 high", 4'b1100, HOLD + 2, 1'b1, 0);
        cfg_write(4'h9, 8'h02);
        press("R4 code2 key2 high", 4'b0100, WIN, 1'b0, 0);
        press("R4 code2 key3 high", 4'b1000, HOLD + 2, 1'b1, 0);
        cfg_write(4'h9, 8'h03);
        press("R4 code3 key3 high", 4'b1000, WIN, 1'b0, 0);

        // R5 / R6: hold length threshold and pulse width
        press("R5 R6 exact hold", 4'b0000, HOLD, 1'b1, 0);
        press("R5 short glitch", 4'b0000, HOLD - 1, 1'b0, 0);

        // R7: held keys give a single pulse, then re-press
        press("R7 held single pulse", 4'b0000, WIN + 10, 1'b1, 0);
        press("R7 re-press", 4'b0000, HOLD + 1, 1'b1, 0);

        // R8: code survives own request
        read_check("R8 code after pulse", 4'h9, 8'h03);

        // R9: write of 0 on the completion edge vs one edge earlier
        press("R9 same-edge write", 4'b0000, WIN, 1'b1, HOLD + 1);
        read_check("R9 code cleared", 4'h9, 8'h00);
        cfg_write(4'h9, 8'h03);
        press("R9 early write", 4'b0000, WIN, 1'b0, HOLD);

        // R1: power-on reset clears code
        cfg_write(4'h9, 8'h02);
        rst = 1'b1; step(); rst = 1'b0; step();
        read_check("R1 code after rst", 4'h9, 8'h00);

        report();
    end

endmodule